// File: doc/BRIEF.md
# UART Transmit Holding Path with Programmable Empty Indication

This block sits between the register interface of a UART and its serial bit shifter. Characters written by software go into a holding store. With the FIFO enabled, the store is a 16-entry first-in first-out queue. With the FIFO disabled, it behaves as a single holding register. The shifter is modelled as a simple handshake: while `sh_ready` is high and the store holds a character, the block presents the oldest character and pulses `sh_load`. That character is removed at the same clock edge.

The block produces three status signals: the holding-empty flag `thre`, the transmitter-empty flag `temt` and the transmit interrupt request `irq`. Two behaviours exist. In the legacy behaviour, `thre` means "nothing waiting", and the interrupt follows it. When the programmable behaviour and the FIFO are both enabled, `thre` instead reports a full FIFO. In that case the interrupt comes from comparing the fill level against a threshold that software selects. Toggling the FIFO enable discards everything that is queued.

Top module: `tx_hold_path`

## Requirements
- R1: After a synchronous active-high reset, the store is empty. In legacy behaviour `thre` reads 1 and `sh_load` reads 0.
- R2: Characters reach `sh_data` in the order they were accepted. `sh_load` is high exactly when `sh_ready` is high and the store is not empty, and the character shown is removed at that clock edge.
- R3: Capacity is 16 with `fifo_en`=1 and 1 with `fifo_en`=0. A write is accepted only if the occupancy before that edge is below capacity, even if a character is loaded at the same edge. Other writes are dropped.
- R4: Unless both `prog_en` and `fifo_en` are 1, `thre` is 1 exactly when the store is empty.
- R5: With `prog_en`=1 and `fifo_en`=1, `thre` is 1 exactly when the FIFO holds 16 characters.
- R6: In legacy behaviour, `irq` equals `irq_en` AND (store empty).
- R7: In programmable behaviour, `irq` equals `irq_en` AND (fill level <= threshold). The threshold is selected by `thr_sel`: 2'b00 gives 0, 2'b01 gives 2, 2'b10 gives 4 (one quarter) and 2'b11 gives 8 (one half).
- R8: `temt` is 1 exactly when the store is empty and `sh_idle` is 1.
- R9: At a clock edge where `fifo_en` differs from its value at the previous edge, the store is emptied, and a write offered at that edge is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write one character this cycle |
| wr_data | input | 8 | Character to write |
| fifo_en | input | 1 | 1 = 16-entry FIFO, 0 = single holding register |
| prog_en | input | 1 | Selects programmable empty indication |
| irq_en | input | 1 | Transmit interrupt enable |
| thr_sel | input | 2 | Interrupt threshold select (R7) |
| sh_ready | input | 1 | Shifter can take a character |
| sh_idle | input | 1 | Shifter has nothing left to send |
| sh_load | output | 1 | Character handed to shifter this cycle |
| sh_data | output | 8 | Oldest character in the store |
| thre | output | 1 | Holding-empty / FIFO-full status |
| temt | output | 1 | Store and shifter both empty |
| irq | output | 1 | Transmit interrupt request |

## Verification
The bench covers all four pairs of `prog_en` and `fifo_en`, each with all four threshold codes. In each case it fills the store with 18 writes while the shifter is blocked, then drains it. Every fill level from 0 to 16 is therefore visited, and the writes past capacity show whether overflow is dropped or corrupts the queue. The drains alternate `sh_idle` to separate `temt` from `thre`. A run of simultaneous writes and loads in single-register mode tests the rule that acceptance is judged on the occupancy before the edge. A run with the interrupt disabled, and a toggle of `fifo_en` with data queued and a write offered at the same edge, cover the gating in R6/R7 and the flush in R9.

// File: rtl/txh_pkg.sv
package txh_pkg;

    typedef enum logic [1:0] {
        THR_EMPTY   = 2'b00,
        THR_TWO     = 2'b01,
        THR_QUARTER = 2'b10,
        THR_HALF    = 2'b11
    } thr_sel_e;

    typedef enum logic {
        IND_LEGACY = 1'b0,
        IND_PROG   = 1'b1
    } ind_mode_e;

    typedef struct packed {
        logic thre;
        logic temt;
        logic irq;
    } tx_status_t;

    function automatic int thr_level(thr_sel_e sel, int depth);
        case (sel)
            THR_EMPTY:   return 0;
            THR_TWO:     return 2;
            THR_QUARTER: return depth / 4;
            default:     return depth / 2;
        endcase
    endfunction

endpackage

// File: rtl/tx_fifo_store.sv
module tx_fifo_store #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          cap_one,
    input  logic          wr_valid,
    input  logic [DW-1:0] wr_data,
    input  logic          pop_ready,
    output logic          load,
    output logic [DW-1:0] load_data,
    output logic [CW-1:0] count
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] cap;
    logic          accept;

    assign cap       = cap_one ? CW'(1) : CW'(DEPTH);
    assign load      = pop_ready && (count != '0);
    assign accept    = wr_valid && (count < cap) && !flush;
    assign load_data = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (accept) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (load) begin
                rd_ptr <= rd_ptr + AW'(1);
            end
            if (accept) begin
                wr_ptr <= wr_ptr + AW'(1);
            end
            case ({accept, load})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/tx_status.sv
module tx_status
    import txh_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic [CW-1:0] count,
    input  ind_mode_e     mode,
    input  thr_sel_e      thr_sel,
    input  logic          irq_en,
    input  logic          sh_idle,
    output tx_status_t    status
);
    logic empty, full, below;

    assign empty = (count == '0);
    assign full  = (count == CW'(DEPTH));
    assign below = (int'(count) <= thr_level(thr_sel, DEPTH));

    always_comb begin
        status.temt = empty && sh_idle;
        if (mode == IND_PROG) begin
            status.thre = full;
            status.irq  = irq_en && below;
        end else begin
            status.thre = empty;
            status.irq  = irq_en && empty;
        end
    end
endmodule

// File: rtl/tx_hold_path.sv
module tx_hold_path
    import txh_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_valid,
    input  logic [DW-1:0] wr_data,
    input  logic          fifo_en,
    input  logic          prog_en,
    input  logic          irq_en,
    input  logic [1:0]    thr_sel,
    input  logic          sh_ready,
    input  logic          sh_idle,
    output logic          sh_load,
    output logic [DW-1:0] sh_data,
    output logic          thre,
    output logic          temt,
    output logic          irq
);
    logic          fifo_en_q;
    logic          flush;
    logic [CW-1:0] count;
    ind_mode_e     mode;
    tx_status_t    status;

    always_ff @(posedge clk) begin
        fifo_en_q <= fifo_en;
    end

    assign flush = !rst && (fifo_en != fifo_en_q);
    assign mode  = (prog_en && fifo_en) ? IND_PROG : IND_LEGACY;

    tx_fifo_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .cap_one   (!fifo_en),
        .wr_valid  (wr_valid),
        .wr_data   (wr_data),
        .pop_ready (sh_ready),
        .load      (sh_load),
        .load_data (sh_data),
        .count     (count)
    );

    tx_status #(.DEPTH(DEPTH)) u_status (
        .count   (count),
        .mode    (mode),
        .thr_sel (thr_sel_e'(thr_sel)),
        .irq_en  (irq_en),
        .sh_idle (sh_idle),
        .status  (status)
    );

    assign thre = status.thre;
    assign temt = status.temt;
    assign irq  = status.irq;
endmodule

// File: rtl/tx_hold_path_chk.sv
module tx_hold_path_chk #(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          fifo_en,
    input logic          prog_en,
    input logic          irq_en,
    input logic          sh_ready,
    input logic          sh_load,
    input logic          thre,
    input logic          temt,
    input logic          irq,
    input logic [CW-1:0] count
);
    AST_NO_LOAD_WHEN_EMPTY: assert property (@(posedge clk) disable iff (rst)
        temt |-> !sh_load) else $error("load while empty"); // R8

    AST_LOAD_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
        sh_load |-> sh_ready) else $error("load without ready"); // R2

    AST_SINGLE_SLOT: assert property (@(posedge clk) disable iff (rst)
        (!fifo_en && $stable(fifo_en)) |-> (count <= CW'(1))) else $error("holding overflow"); // R3

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH)) else $error("fifo overflow"); // R3

    AST_LEGACY_IRQ: assert property (@(posedge clk) disable iff (rst)
        (!(prog_en && fifo_en) && irq_en) |-> (irq == thre)) else $error("legacy irq"); // R6

    AST_FULL_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
        (prog_en && fifo_en && thre) |-> !irq) else $error("irq while full"); // R7

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        (fifo_en != $past(fifo_en)) |=> !sh_load) else $error("flush left data"); // R9
endmodule

bind tx_hold_path tx_hold_path_chk #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .fifo_en  (fifo_en),
    .prog_en  (prog_en),
    .irq_en   (irq_en),
    .sh_ready (sh_ready),
    .sh_load  (sh_load),
    .thre     (thre),
    .temt     (temt),
    .irq      (irq),
    .count    (count)
);

// File: tb/tb_tx_hold_path.sv
module tb_tx_hold_path;
    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic       fifo_en = 1'b0;
    logic       prog_en = 1'b0;
    logic       irq_en = 1'b0;
    logic [1:0] thr_sel = 2'b00;
    logic       sh_ready = 1'b0;
    logic       sh_idle = 1'b1;
    logic       sh_load;
    logic [7:0] sh_data;
    logic       thre, temt, irq;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [7:0] mq [DEPTH];
    int mh = 0, mt = 0, mc = 0;
    logic mprev = 1'b0;

    always #2 clk = ~clk;

    tx_hold_path #(.DW(8), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
        .fifo_en(fifo_en), .prog_en(prog_en), .irq_en(irq_en), .thr_sel(thr_sel),
        .sh_ready(sh_ready), .sh_idle(sh_idle), .sh_load(sh_load), .sh_data(sh_data),
        .thre(thre), .temt(temt), .irq(irq)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (fill %0d prog %0b fifo %0b sel %0d)",
                     req, act, exp, mc, prog_en, fifo_en, thr_sel);
        end
    endtask

    // Called at a falling edge; ends at the next falling edge.
    task automatic step(input bit wr, input logic [7:0] d, input bit rdy, input bit idle);
        bit prog, ld, acc, fl;
        int thr, cap;
        wr_valid = wr; wr_data = d; sh_ready = rdy; sh_idle = idle;
        #1;
        prog = prog_en && fifo_en;
        thr  = (thr_sel == 2'b00) ? 0 : (thr_sel == 2'b01) ? 2 :
               (thr_sel == 2'b10) ? DEPTH / 4 : DEPTH / 2;
        ld   = rdy && (mc > 0);
        if (prog) begin
            chk("R5", int'(thre), int'(mc == DEPTH));
            chk("R7", int'(irq), int'(irq_en && (mc <= thr)));
        end else begin
            chk("R4", int'(thre), int'(mc == 0));
            chk("R6", int'(irq), int'(irq_en && (mc == 0)));
        end
        chk("R8", int'(temt), int'((mc == 0) && idle));
        chk("R2", int'(sh_load), int'(ld));
        if (ld) chk("R2", int'(sh_data), int'(mq[mh]));
        @(posedge clk);
        fl = (fifo_en != mprev);
        mprev = fifo_en;
        cap = fifo_en ? DEPTH : 1;
        acc = wr && (mc < cap) && !fl;
        if (fl) begin
            mh = 0; mt = 0; mc = 0;
        end else begin
            if (ld) begin mh = (mh + 1) % DEPTH; mc--; end
            if (acc) begin mq[mt] = d; mt = (mt + 1) % DEPTH; mc++; end
        end
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        mprev = fifo_en;
        // R1: reset state in legacy behaviour
        irq_en = 1'b1;
        chk("R1", int'(thre), 1);
        chk("R1", int'(sh_load), 0);
        step(0, 8'h00, 1, 1);

        // Sweep all behaviours and thresholds: fill past capacity, then drain (R3 drops)
        for (int p = 0; p < 2; p++) begin
            for (int f = 0; f < 2; f++) begin
                for (int s = 0; s < 4; s++) begin
                    prog_en = p[0]; fifo_en = f[0]; thr_sel = s[1:0]; irq_en = 1'b1;
                    for (int i = 0; i < 18; i++)
                        step(1, 8'((p * 64) + (f * 32) + (s * 8) + i + 1), 0, 1);
                    for (int i = 0; i < 18; i++)
                        step(0, 8'h00, 1, i[0]);
                end
            end
        end

        // R3: single-register mode, write and load in the same cycle
        prog_en = 1'b0; fifo_en = 1'b0;
        step(0, 8'h00, 0, 1);
        for (int i = 0; i < 10; i++)
            step(1, 8'(8'hA0 + i), 1, 0);
        for (int i = 0; i < 3; i++)
            step(0, 8'h00, 1, 1);

        // R6/R7: interrupt disabled in both behaviours
        irq_en = 1'b0;
        for (int p = 0; p < 2; p++) begin
            prog_en = p[0]; fifo_en = 1'b1; thr_sel = 2'b11;
            for (int i = 0; i < 17; i++) step(1, 8'(8'h30 + i), 0, 1);
            for (int i = 0; i < 17; i++) step(0, 8'h00, 1, 1);
        end

        // R9: toggle fifo_en with data queued and a write at the flush edge
        irq_en = 1'b1; prog_en = 1'b1; fifo_en = 1'b1; thr_sel = 2'b01;
        for (int i = 0; i < 6; i++) step(1, 8'(8'h50 + i), 0, 1);
        fifo_en = 1'b0;
        step(1, 8'hEE, 0, 1);
        chk("R9", int'(thre), 1);
        step(0, 8'h00, 1, 1);
        step(1, 8'h77, 0, 1);
        fifo_en = 1'b1;
        step(0, 8'h00, 0, 1);
        chk("R9", int'(sh_load), 0);
        step(0, 8'h00, 1, 1);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule